// File: doc/BRIEF.md
# Infrared Receive Symbol FIFO with Interrupt Flags

This block sits between an infrared line sampler and a host processor. The sampler hands it one 8-bit run-length symbol at a time, each marked by a single-cycle strobe. It also gives a single-cycle pulse when a packet has ended. The block stores the symbols in a first-in first-out buffer. The host drains that buffer through a small register interface.

Three events are kept as sticky flags in a status word: a lost symbol (overflow), the end of a packet, and the fill level passing a programmable threshold (data available). The host clears each flag by writing a 1 to its bit. The status word also carries the current fill count. An enable word picks which flags drive the single interrupt line, and the same word holds the threshold. The host services the interrupt by reading the status, writing the flags back to clear them, and popping as many symbols as the count reports.

Register addresses are 0 for the enable word, 1 for the status word and 2 for the data port. Register reads return their data combinationally in the cycle the address is presented. A read of the data port with the read strobe high takes effect at the next clock edge.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: After reset the fill count is 0, all three flags are 0, the enable word reads 0 and `irq` is low.
- R2: A read strobe at address 2 returns the oldest stored symbol in bits 7:0 with bits 31:8 at zero, and removes that symbol at the clock edge. Symbols leave in the order they arrived.
- R3: A symbol strobe that arrives while the FIFO holds DEPTH entries, with no successful pop in the same cycle, is discarded. Status bit 0 (overflow) reads 1 from the next cycle onward.
- R4: A packet-end pulse sets status bit 1 in the next cycle, whatever the fill level.
- R5: The enable word at address 0 holds the enables in bit 0 (overflow), bit 1 (packet end) and bit 4 (data available), and the threshold in bits starting at 8, $clog2(DEPTH) bits wide. Status bit 4 is set in the cycle after any cycle in which the fill count is greater than the threshold.
- R6: Status bits starting at 8 report the current fill count, 0 to DEPTH. All status bits not named in R3 to R6 read 0.
- R7: A write to address 1 clears every flag whose bit is 1 in the written data, so 0xFF clears all three. A flag whose setting event occurs in the same cycle stays set.
- R8: `irq` is high exactly when some status flag is 1 and its enable bit is 1.
- R9: A push and a successful pop in the same cycle leave the count unchanged. This holds when the FIFO is full, and in that case the pushed symbol is kept.
- R10: A data-port read on an empty FIFO returns 0 and leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Symbol strobe from the sampler |
| sym_data | input | 8 | Run-length symbol |
| pkt_end | input | 1 | Packet-end pulse from the sampler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 2) |
| reg_addr | input | 2 | Register address: 0 enable, 1 status, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the FIFO sitting exactly at DEPTH entries while a new symbol arrives. The outcome there depends on whether a data-port read lands in the same cycle: the symbol is either dropped with the overflow flag set, or accepted with the count held. Random traffic with pops roughly as frequent as pushes seldom fills the buffer. Directed phases therefore push DEPTH symbols with no pops, push once more with no pop, and then push and pop together at the full mark. Another directed phase writes the clear mask in the same cycle as a packet-end pulse, to show that the set takes priority.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    localparam logic [1:0] ADDR_IEN  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int BIT_OVF   = 0;
    localparam int BIT_PEND  = 1;
    localparam int BIT_AVAIL = 4;
    localparam int FIELD_LSB = 8;

    typedef struct packed {
        logic avail;
        logic pend;
        logic ovf;
    } irq_flags_t;
endpackage

// File: rtl/ir_rx_store.sv
module ir_rx_store #(
    parameter int DEPTH = 64,
    parameter int CNTW  = $clog2(DEPTH + 1),
    parameter int PTRW  = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [7:0]      push_data,
    input  logic            pop,
    output logic [7:0]      head_data,
    output logic [CNTW-1:0] count,
    output logic            drop
);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
    localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);

    typedef struct packed {
        logic [PTRW-1:0] wptr;
        logic [PTRW-1:0] rptr;
        logic [CNTW-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [7:0] mem_q [DEPTH];
    logic full, empty, pop_ok, push_ok;

    always_comb begin
        full    = (st_q.cnt == FULL_CNT);
        empty   = (st_q.cnt == '0);
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
        drop    = push && !push_ok;

        st_d = st_q;
        if (push_ok) st_d.wptr = (st_q.wptr == LAST_PTR) ? '0 : st_q.wptr + 1'b1;
        if (pop_ok)  st_d.rptr = (st_q.rptr == LAST_PTR) ? '0 : st_q.rptr + 1'b1;
        if (push_ok && !pop_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (pop_ok && !push_ok) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= push_data;
    end

    assign head_data = empty ? 8'h00 : mem_q[st_q.rptr];
    assign count     = st_q.cnt;
endmodule

// File: rtl/ir_rx_flags.sv
module ir_rx_flags
    import ir_rx_pkg::*;
#(
    parameter int LVLW = 6,
    parameter int CNTW = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ien_wr,
    input  logic            stat_wr,
    input  logic [31:0]     wdata,
    input  logic            drop,
    input  logic            pkt_end,
    input  logic [CNTW-1:0] count,
    output irq_flags_t      flags,
    output irq_flags_t      en,
    output logic [LVLW-1:0] level,
    output logic            irq
);
    typedef struct packed {
        irq_flags_t      en;
        logic [LVLW-1:0] level;
        irq_flags_t      flags;
    } flag_state_t;

    flag_state_t fs_d, fs_q;
    irq_flags_t  clr, evt;

    always_comb begin
        clr.ovf   = stat_wr && wdata[BIT_OVF];
        clr.pend  = stat_wr && wdata[BIT_PEND];
        clr.avail = stat_wr && wdata[BIT_AVAIL];
        evt.ovf   = drop;
        evt.pend  = pkt_end;
        evt.avail = (count > CNTW'(fs_q.level));

        fs_d = fs_q;
        fs_d.flags = (fs_q.flags & ~clr) | evt;
        if (ien_wr) begin
            fs_d.en.ovf   = wdata[BIT_OVF];
            fs_d.en.pend  = wdata[BIT_PEND];
            fs_d.en.avail = wdata[BIT_AVAIL];
            fs_d.level    = wdata[FIELD_LSB +: LVLW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign flags = fs_q.flags;
    assign en    = fs_q.en;
    assign level = fs_q.level;
    assign irq   = |(fs_q.flags & fs_q.en);
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sym_valid,
    input  logic [7:0]  sym_data,
    input  logic        pkt_end,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int LVLW = $clog2(DEPTH);

    logic [7:0]      head_data;
    logic [CNTW-1:0] fill_cnt;
    logic            sym_drop;
    logic            pop_req;
    irq_flags_t      stat_flags, ien_bits;
    logic [LVLW-1:0] avail_level;

    assign pop_req = reg_rd && (reg_addr == ADDR_DATA);

    ir_rx_store #(.DEPTH(DEPTH), .CNTW(CNTW), .PTRW(LVLW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sym_valid),
        .push_data (sym_data),
        .pop       (pop_req),
        .head_data (head_data),
        .count     (fill_cnt),
        .drop      (sym_drop)
    );

    ir_rx_flags #(.LVLW(LVLW), .CNTW(CNTW)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_wr  (reg_wr && (reg_addr == ADDR_IEN)),
        .stat_wr (reg_wr && (reg_addr == ADDR_STAT)),
        .wdata   (reg_wdata),
        .drop    (sym_drop),
        .pkt_end (pkt_end),
        .count   (fill_cnt),
        .flags   (stat_flags),
        .en      (ien_bits),
        .level   (avail_level),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_IEN: begin
                reg_rdata[BIT_OVF]   = ien_bits.ovf;
                reg_rdata[BIT_PEND]  = ien_bits.pend;
                reg_rdata[BIT_AVAIL] = ien_bits.avail;
                reg_rdata[FIELD_LSB +: LVLW] = avail_level;
            end
            ADDR_STAT: begin
                reg_rdata[BIT_OVF]   = stat_flags.ovf;
                reg_rdata[BIT_PEND]  = stat_flags.pend;
                reg_rdata[BIT_AVAIL] = stat_flags.avail;
                reg_rdata[FIELD_LSB +: CNTW] = fill_cnt;
            end
            ADDR_DATA: reg_rdata[7:0] = head_data;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ir_rx_fifo_irq_chk.sv
module ir_rx_fifo_irq_chk
    import ir_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNTW  = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sym_valid,
    input logic            pkt_end,
    input logic            reg_wr,
    input logic            reg_rd,
    input logic [1:0]      reg_addr,
    input logic [31:0]     reg_wdata,
    input logic [CNTW-1:0] count,
    input irq_flags_t      flags
);
    logic pop_c, full_c, empty_c;
    assign pop_c   = reg_rd && (reg_addr == ADDR_DATA);
    assign full_c  = (count == CNTW'(DEPTH));
    assign empty_c = (count == '0);

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNTW'(DEPTH));

    assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && full_c && !pop_c) |=> flags.ovf);

    assert_pend_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> flags.pend);

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[BIT_PEND] && !pkt_end) |=> !flags.pend);

    assert_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && pop_c && !empty_c) |=> $stable(count));

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_c && empty_c && !sym_valid) |=> (count == '0));
endmodule

bind ir_rx_fifo_irq ir_rx_fifo_irq_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_valid (sym_valid),
    .pkt_end   (pkt_end),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .count     (fill_cnt),
    .flags     (stat_flags)
);

// File: tb/test_ir_rx_fifo_irq.sv
module test_ir_rx_fifo_irq;
    localparam int DEPTH = 64;
    localparam int LVLW  = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0;
    logic [7:0]  sym_data = '0;
    logic        pkt_end = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int unsigned q[$];
    bit m_ovf, m_pend, m_avail;
    bit e_ovf, e_pend, e_avail;
    int m_level;

    always #5 clk = ~clk;

    ir_rx_fifo_irq #(.DEPTH(DEPTH)) i_ir_rx_fifo_irq (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
        .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_status();
        return (32'(q.size()) << 8) | (32'(m_avail) << 4) | (32'(m_pend) << 1) | 32'(m_ovf);
    endfunction

    function automatic logic [31:0] exp_ien();
        return (32'(m_level) << 8) | (32'(e_avail) << 4) | (32'(e_pend) << 1) | 32'(e_ovf);
    endfunction

    function automatic logic [31:0] exp_data();
        return (q.size() == 0) ? 32'd0 : 32'(q[0]);
    endfunction

    function automatic logic exp_irq();
        return (m_ovf && e_ovf) || (m_pend && e_pend) || (m_avail && e_avail);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then update the model at the edge.
    task automatic step(input bit sv, input logic [7:0] sd, input bit pe, input bit wr,
                        input bit rd, input logic [1:0] ad, input logic [31:0] wd, input string tag);
        int  cnt_b;
        bit  pop_ok, drop;
        logic [7:0] clr;
        @(negedge clk);
        sym_valid = sv; sym_data = sd; pkt_end = pe;
        reg_wr = wr; reg_rd = rd; reg_addr = ad; reg_wdata = wd;
        #1;
        case (ad)
            2'd0: check({tag, " R5 enable word"}, reg_rdata, exp_ien());
            2'd1: check({tag, " R6 status word"}, reg_rdata, exp_status());
            2'd2: check({tag, " R2 data port"}, reg_rdata, exp_data());
            default: check({tag, " R6 unused address"}, reg_rdata, 32'd0);
        endcase
        check({tag, " R8 irq"}, 32'(irq), 32'(exp_irq()));
        @(posedge clk);
        cnt_b  = q.size();
        pop_ok = rd && (ad == 2'd2) && (cnt_b > 0);
        drop   = sv && (cnt_b == DEPTH) && !pop_ok;
        clr    = (wr && ad == 2'd1) ? wd[7:0] : 8'h00;
        m_ovf   = (m_ovf && !clr[0]) || drop;
        m_pend  = (m_pend && !clr[1]) || pe;
        m_avail = (m_avail && !clr[4]) || (cnt_b > m_level);
        if (wr && ad == 2'd0) begin
            e_ovf = wd[0]; e_pend = wd[1]; e_avail = wd[4];
            m_level = int'(wd[8 +: LVLW]);
        end
        if (pop_ok) void'(q.pop_front());
        if (sv && !drop) q.push_back(int'(sd));
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 0, 0, 2'd1, 32'd0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int unsigned r;
        void'($urandom(32'd1234));
        m_level = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        check("R1 status after reset", reg_rdata, 32'd0);
        check("R1 irq after reset", 32'(irq), 32'd0);
        step(0, 8'h00, 0, 0, 0, 2'd0, 32'd0, "R1 enable after reset");

        // R10: pop on empty
        step(0, 8'h00, 0, 0, 1, 2'd2, 32'd0, "R10 empty pop");
        @(negedge clk); #1;
        check("R10 count stays 0", reg_rdata, exp_status());

        // R5: program level 3, enable all
        step(0, 8'h00, 0, 1, 0, 2'd0, 32'h0000_0313, "R5 program");
        for (int i = 0; i < 5; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 2'd1, 32'd0, "R5 fill");
        idle("R5 threshold");
        check("R5 avail flag set", 32'(reg_rdata[4]), 32'd1);

        // R2: drain in order
        for (int i = 0; i < 5; i++) step(0, 8'h00, 0, 0, 1, 2'd2, 32'd0, "R2 drain");
        step(0, 8'h00, 0, 1, 0, 2'd1, 32'h0000_00FF, "R7 clear all");
        idle("R7 after clear");
        check("R7 flags cleared", reg_rdata & 32'hFF, 32'd0);

        // R4 and R7: packet end in the same cycle as its clear
        step(0, 8'h00, 1, 1, 0, 2'd1, 32'h0000_0002, "R7 set wins");
        idle("R4 pend");
        check("R4 pend flag set", 32'(reg_rdata[1]), 32'd1);
        step(0, 8'h00, 0, 1, 0, 2'd1, 32'h0000_0002, "R7 w1c pend");
        idle("R7 pend cleared");
        check("R7 pend cleared", 32'(reg_rdata[1]), 32'd0);

        // R3 / R9: fill to full, then overflow, then balanced push and pop at full
        step(0, 8'h00, 0, 1, 0, 2'd0, 32'h0000_3F01, "R5 max level");
        for (int i = 0; i < DEPTH; i++) step(1, 8'(i), 0, 0, 0, 2'd1, 32'd0, "R3 fill");
        idle("R3 full");
        check("R6 full count", reg_rdata >> 8, 32'(DEPTH));
        step(1, 8'hEE, 0, 0, 0, 2'd1, 32'd0, "R3 overflow push");
        idle("R3 after overflow");
        check("R3 ovf flag set", 32'(reg_rdata[0]), 32'd1);
        check("R3 irq on ovf", 32'(irq), 32'd1);
        check("R3 symbol dropped", reg_rdata >> 8, 32'(DEPTH));
        step(1, 8'hAB, 0, 0, 1, 2'd2, 32'd0, "R9 push+pop full");
        idle("R9 count held");
        check("R9 count at full", reg_rdata >> 8, 32'(DEPTH));
        step(0, 8'h00, 0, 1, 0, 2'd1, 32'h0000_00FF, "R7 clear");
        for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 0, 1, 2'd2, 32'd0, "R2 drain full");
        idle("R9 last kept");

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            r = $urandom_range(0, 99);
            v = 8'($urandom);
            if (r < 40)      step($urandom_range(0, 9) < 5, v, $urandom_range(0, 19) == 0, 0, 1, 2'd2, 32'd0, "rnd pop");
            else if (r < 50) step($urandom_range(0, 9) < 5, v, $urandom_range(0, 19) == 0, 1, 0, 2'd1, 32'($urandom), "rnd w1c");
            else if (r < 53) step($urandom_range(0, 9) < 5, v, 0, 1, 0, 2'd0, 32'($urandom), "rnd ien");
            else             step($urandom_range(0, 9) < 6, v, $urandom_range(0, 19) == 0, 0, $urandom_range(0, 1) == 1, 2'($urandom), 32'd0, "rnd read");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule